// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. It takes the accumulator value and a second operand, picked either from a register source or from an immediate field, and applies one of ten operations: four add and subtract forms, three bitwise forms, compare, increment and decrement. The result leaves the block in the same cycle as the inputs arrive. A qualifier tells the datapath whether the result is to be written back.

Each operation also produces a set of status bits: sign, zero, half carry, parity and carry. These bits are stored in a flag register at the clock edge when the caller enables the flag write. The stored flags are presented as a byte in which each flag has a fixed bit, and the unused bits hold constant values.

Each class of operation sets the flags by its own rule. The bitwise forms clear the carry. Compare sets the flags but never asks for a write of the result. Increment and decrement pass the caller's current carry through unchanged. The surrounding datapath supplies that carry on `carry_i` and uses the same input as the carry into add-with-carry and subtract-with-borrow.

Top module: `acc_alu_flags`

## Requirements
- R1: While reset is active, and after it is released with no flag write, `flags_o` reads 8'h02.
- R2: Op code 0 (add) gives acc+operand and ignores `carry_i`. Op code 1 (add with carry) gives acc+operand+`carry_i`. Both take the result modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R3: Op code 2 (subtract) gives acc-operand and op code 3 (subtract with borrow) gives acc-operand-`carry_i`, both modulo 256. CY is 1 when a borrow out of bit 7 occurs. AC is 1 when the low nibble needs a borrow into bit 4.
- R4: Op code 7 (compare) sets the flags exactly as subtract would, and `result_we_o` is 0.
- R5: Op code 4 (AND) sets CY to 0 and AC to 1.
- R6: Op code 5 (XOR) and op code 6 (OR) set both CY and AC to 0.
- R7: Op code 8 (increment) and op code 9 (decrement) act on the selected operand alone and wrap modulo 256. The new CY equals `carry_i`. AC is the carry out of bit 3 for increment and the borrow into bit 4 for decrement.
- R8: With `use_imm_i`=1 the operand is `imm_opnd_i`; with `use_imm_i`=0 it is `reg_opnd_i`.
- R9: The flag byte layout is S=bit7, Z=bit6, AC=bit4, P=bit2, CY=bit0. Bit 1 is always 1 and bits 3 and 5 are always 0. Z is 1 for a zero result. P is 1 when the result has an even number of one bits. S is result bit 7.
- R10: With `flag_we_i`=0 the flag byte does not change. The result and `result_we_o` are still produced.
- R11: Op codes 10 to 15 are undefined. They give `result_we_o`=0 and leave the flag byte unchanged, even when `flag_we_i`=1.
- R12: `result_o` and `result_we_o` follow the inputs in the same cycle. The new flag byte appears on `flags_o` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 8 | Accumulator value |
| reg_opnd_i | input | 8 | Operand from a register |
| imm_opnd_i | input | 8 | Operand from the immediate field |
| use_imm_i | input | 1 | Selects the immediate operand |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Current carry |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result is to be written to the accumulator |
| flags_o | output | 8 | Stored flag byte |

## Verification
Two functions can fall in the same cycle. One is the combinational result of a new operation. The other is the flag register taking in the status bits of the operation before it. The bench provokes this by issuing operations back to back, mixing compare, increment and decrement with `flag_we_i` toggling and with undefined codes in between. The result and write qualifier are judged against a model in the issue cycle. The flag byte is judged one edge later from a scoreboard queue, so a flag value that leaks from the wrong operation, or an update that should have been suppressed, shows up as a mismatch.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_AND = 4'd4,
      OP_XOR = 4'd5,
      OP_OR  = 4'd6,
      OP_CMP = 4'd7,
      OP_INC = 4'd8,
      OP_DEC = 4'd9
   } alu_op_e;

   localparam int FB_S   = 7;
   localparam int FB_Z   = 6;
   localparam int FB_AC  = 4;
   localparam int FB_P   = 2;
   localparam int FB_ONE = 1;
   localparam int FB_CY  = 0;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } flag_set_t;

   typedef struct packed {
      logic is_arith;
      logic is_logic;
      logic is_incdec;
      logic do_sub;
      logic use_cin;
      logic wr_res;
      logic valid;
      logic [1:0] lsel;
   } alu_ctl_t;

   function automatic logic [7:0] pack_flags(flag_set_t f);
      logic [7:0] b;
      b = 8'h00;
      b[FB_S]   = f.s;
      b[FB_Z]   = f.z;
      b[FB_AC]  = f.ac;
      b[FB_P]   = f.p;
      b[FB_ONE] = 1'b1;
      b[FB_CY]  = f.cy;
      return b;
   endfunction

endpackage

// File: rtl/acc_opnd_mux.sv
module acc_opnd_mux #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] reg_opnd,
   input  logic [DATA_W-1:0] imm_opnd,
   input  logic              use_imm,
   output logic [DATA_W-1:0] opnd
);
   assign opnd = use_imm ? imm_opnd : reg_opnd;
endmodule

// File: rtl/acc_op_decode.sv
module acc_op_decode
   import acc_alu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output alu_ctl_t        ctl
);
   always_comb begin
      ctl = '0;
      ctl.valid = 1'b1;
      unique case (op)
         OP_ADD: begin ctl.is_arith = 1'b1; ctl.wr_res = 1'b1; end
         OP_ADC: begin ctl.is_arith = 1'b1; ctl.use_cin = 1'b1; ctl.wr_res = 1'b1; end
         OP_SUB: begin ctl.is_arith = 1'b1; ctl.do_sub = 1'b1; ctl.wr_res = 1'b1; end
         OP_SBB: begin
            ctl.is_arith = 1'b1; ctl.do_sub = 1'b1;
            ctl.use_cin  = 1'b1; ctl.wr_res = 1'b1;
         end
         OP_CMP: begin ctl.is_arith = 1'b1; ctl.do_sub = 1'b1; end
         OP_AND: begin ctl.is_logic = 1'b1; ctl.lsel = 2'd0; ctl.wr_res = 1'b1; end
         OP_XOR: begin ctl.is_logic = 1'b1; ctl.lsel = 2'd1; ctl.wr_res = 1'b1; end
         OP_OR:  begin ctl.is_logic = 1'b1; ctl.lsel = 2'd2; ctl.wr_res = 1'b1; end
         OP_INC: begin ctl.is_incdec = 1'b1; ctl.wr_res = 1'b1; end
         OP_DEC: begin ctl.is_incdec = 1'b1; ctl.do_sub = 1'b1; ctl.wr_res = 1'b1; end
         default: ctl.valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
   parameter int DATA_W       = 8,
   parameter bit NIBBLE_SPLIT = 1'b1
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              cy,
   output logic              ac
);
   localparam int NIB_W = 4;

   logic [DATA_W-1:0] y_eff;
   logic              c_eff;
   logic [DATA_W:0]   full;
   logic              c_nib;

   assign y_eff = sub ? ~y : y;
   assign c_eff = sub ? ~cin : cin;
   assign full  = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
   assign sum   = full[DATA_W-1:0];
   assign cy    = sub ? ~full[DATA_W] : full[DATA_W];

   generate
      if (NIBBLE_SPLIT) begin : g_nib_add
         logic [NIB_W:0] low;
         assign low   = {1'b0, x[NIB_W-1:0]} + {1'b0, y_eff[NIB_W-1:0]}
                        + {{NIB_W{1'b0}}, c_eff};
         assign c_nib = low[NIB_W];
      end else begin : g_nib_xor
         assign c_nib = x[NIB_W] ^ y_eff[NIB_W] ^ full[NIB_W];
      end
   endgenerate

   assign ac = sub ? ~c_nib : c_nib;
endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] d,
   output logic [7:0] q
);
   localparam logic [7:0] RST_VAL = 8'h02;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
   end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit NIBBLE_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] reg_opnd_i,
   input  logic [DATA_W-1:0] imm_opnd_i,
   input  logic              use_imm_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic              carry_i,
   input  logic              flag_we_i,
   output logic [DATA_W-1:0] result_o,
   output logic              result_we_o,
   output logic [7:0]        flags_o
);
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 5) begin : g_bad_width
         $error("acc_alu_flags: DATA_W must be at least 5");
      end
   endgenerate

   logic [DATA_W-1:0] opnd;
   alu_ctl_t          ctl;
   logic [DATA_W-1:0] as_x, as_y, as_sum, lres, res;
   logic              as_cin, as_cy, as_ac;
   flag_set_t         fl;

   acc_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .reg_opnd(reg_opnd_i), .imm_opnd(imm_opnd_i),
      .use_imm(use_imm_i), .opnd(opnd)
   );

   acc_op_decode u_dec (.op(op_i), .ctl(ctl));

   always_comb begin
      if (ctl.is_incdec) begin
         as_x   = opnd;
         as_y   = ONE;
         as_cin = 1'b0;
      end else begin
         as_x   = acc_i;
         as_y   = opnd;
         as_cin = ctl.use_cin & carry_i;
      end
   end

   acc_addsub #(.DATA_W(DATA_W), .NIBBLE_SPLIT(NIBBLE_SPLIT)) u_as (
      .x(as_x), .y(as_y), .cin(as_cin), .sub(ctl.do_sub),
      .sum(as_sum), .cy(as_cy), .ac(as_ac)
   );

   always_comb begin
      unique case (ctl.lsel)
         2'd0:    lres = acc_i & opnd;
         2'd1:    lres = acc_i ^ opnd;
         default: lres = acc_i | opnd;
      endcase
   end

   always_comb begin
      res = ctl.is_logic ? lres : as_sum;
      if (!ctl.valid) res = '0;
   end

   always_comb begin
      fl.s = res[DATA_W-1];
      fl.z = (res == '0);
      fl.p = ~^res;
      if (ctl.is_logic) begin
         fl.cy = 1'b0;
         fl.ac = (ctl.lsel == 2'd0);
      end else if (ctl.is_incdec) begin
         fl.cy = carry_i;
         fl.ac = as_ac;
      end else begin
         fl.cy = as_cy;
         fl.ac = as_ac;
      end
   end

   acc_flag_reg u_freg (
      .clk(clk), .rst_n(rst_n),
      .load(flag_we_i & ctl.valid),
      .d(pack_flags(fl)), .q(flags_o)
   );

   assign result_o    = res;
   assign result_we_o = ctl.valid & ctl.wr_res;
endmodule

// File: rtl/acc_alu_flags_chk.sv
module acc_alu_flags_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OP_W-1:0]   op_i,
   input logic              carry_i,
   input logic              flag_we_i,
   input logic [DATA_W-1:0] result_o,
   input logic              result_we_o,
   input logic [7:0]        flags_o
);
   // R9
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[FB_ONE] && !flags_o[3] && !flags_o[5]);

   // R4
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CMP) |-> !result_we_o);

   // R10
   hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we_i |=> $stable(flags_o));

   // R11
   undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd9) |=> $stable(flags_o));

   // R11
   undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd9) |-> !result_we_o);

   // R7
   incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && (op_i == OP_INC || op_i == OP_DEC))
      |=> (flags_o[FB_CY] == $past(carry_i)));

   // R5
   logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR))
      |=> !flags_o[FB_CY]);

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && result_we_o) |=> (flags_o[FB_Z] == ($past(result_o) == '0)));
endmodule

bind acc_alu_flags acc_alu_flags_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .carry_i(carry_i),
   .flag_we_i(flag_we_i), .result_o(result_o),
   .result_we_o(result_we_o), .flags_o(flags_o)
);

// File: tb/acc_alu_flags_tb_top.sv
module acc_alu_flags_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [7:0] flags;
      string      tag;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] acc_i = 8'h00, reg_opnd_i = 8'h00, imm_opnd_i = 8'h00;
   logic       use_imm_i = 1'b0;
   logic [3:0] op_i = 4'd0;
   logic       carry_i = 1'b0, flag_we_i = 1'b0;
   logic [7:0] result_o;
   logic       result_we_o;
   logic [7:0] flags_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] model_flags = 8'h02;
   exp_item_t  sb_q[$];
   bit         done = 1'b0;

   acc_alu_flags dut_i (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .reg_opnd_i(reg_opnd_i),
      .imm_opnd_i(imm_opnd_i), .use_imm_i(use_imm_i), .op_i(op_i),
      .carry_i(carry_i), .flag_we_i(flag_we_i), .result_o(result_o),
      .result_we_o(result_we_o), .flags_o(flags_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input int op, input int a, input int b, input int c,
                                 output logic we, output logic [7:0] r,
                                 output logic [7:0] f, output logic upd);
      int t;
      logic cy, ac, s, z, p;
      t = 0; cy = 1'b0; ac = 1'b0; we = 1'b1; upd = 1'b1;
      case (op)
         0: begin t = a + b; cy = (t > 255); ac = ((a % 16) + (b % 16)) > 15; end
         1: begin t = a + b + c; cy = (t > 255); ac = ((a % 16) + (b % 16) + c) > 15; end
         2, 7: begin t = a - b; cy = (a < b); ac = (a % 16) < (b % 16); end
         3: begin t = a - b - c; cy = (a < b + c); ac = (a % 16) < ((b % 16) + c); end
         4: begin t = a & b; ac = 1'b1; end
         5: t = a ^ b;
         6: t = a | b;
         8: begin t = b + 1; cy = c[0]; ac = (b % 16) == 15; end
         9: begin t = b - 1; cy = c[0]; ac = (b % 16) == 0; end
         default: begin we = 1'b0; upd = 1'b0; end
      endcase
      if (op == 7) we = 1'b0;
      r = upd ? 8'(t & 255) : 8'h00;
      s = r[7];
      z = (r == 8'h00);
      p = ~^r;
      f = {s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
   endfunction

   task automatic do_op(string tag, int op, logic [7:0] a, logic [7:0] rg, logic [7:0] im,
                        logic ui, logic c, logic fwe);
      logic we, upd;
      logic [7:0] r, f;
      exp_item_t it;
      @(negedge clk);
      op_i = 4'(op); acc_i = a; reg_opnd_i = rg; imm_opnd_i = im;
      use_imm_i = ui; carry_i = c; flag_we_i = fwe;
      #1;
      model(op, int'(a), int'(ui ? im : rg), int'(c), we, r, f, upd);
      if (we) check8(tag, "result", result_o, r);
      check8(tag, "result_we", {7'b0, result_we_o}, {7'b0, we});
      if (fwe && upd) model_flags = f;
      it.flags = model_flags;
      it.tag   = tag;
      sb_q.push_back(it);
   endtask

   // monitor: pops one expected flag byte after each edge that follows an issue
   always @(posedge clk) begin
      exp_item_t it;
      #1;
      if (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         check8(it.tag, "flags", flags_o, it.flags);
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 2);
      check8("R1", "flags in reset", flags_o, 8'h02);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1", "flags after reset", flags_o, 8'h02);

      // R2 add / add with carry, carry_i ignored by plain add
      do_op("R2", 0, 8'h3C, 8'h48, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R2", 0, 8'hF8, 8'h08, 8'h00, 1'b0, 1'b0, 1'b1);
      do_op("R2", 1, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R2", 1, 8'h0E, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1);
      // R3 subtract / borrow
      do_op("R3", 2, 8'h10, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R3", 2, 8'h05, 8'h07, 8'h00, 1'b0, 1'b0, 1'b1);
      do_op("R3", 3, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R3", 3, 8'h44, 8'h43, 8'h00, 1'b0, 1'b1, 1'b1);
      // R4 compare
      do_op("R4", 7, 8'h20, 8'h00, 8'h20, 1'b1, 1'b0, 1'b1);
      do_op("R4", 7, 8'h01, 8'h00, 8'h80, 1'b1, 1'b1, 1'b1);
      // R5 and R6 logical
      do_op("R5", 4, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R5", 4, 8'hFF, 8'h81, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R6", 5, 8'hAA, 8'h55, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R6", 6, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      // R7 increment / decrement keep carry_i
      do_op("R7", 8, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1);
      do_op("R7", 8, 8'h00, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R7", 9, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R7", 9, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1);
      // R8 operand select
      do_op("R8", 0, 8'h01, 8'h10, 8'h20, 1'b1, 1'b0, 1'b1);
      do_op("R8", 0, 8'h01, 8'h10, 8'h20, 1'b0, 1'b0, 1'b1);
      // R10 flags held when write disabled
      do_op("R10", 2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
      do_op("R10", 8, 8'h00, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b0);
      // R11 undefined codes
      do_op("R11", 10, 8'h12, 8'h34, 8'h00, 1'b0, 1'b1, 1'b1);
      do_op("R11", 15, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
      // R12 and R9 back-to-back mixed traffic
      for (int i = 0; i < 400; i++) begin
         do_op((i % 2 == 0) ? "R12" : "R9", int'($urandom_range(0, 11)),
               8'($urandom), 8'($urandom), 8'($urandom),
               1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0));
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule